// File: doc/BRIEF.md
# Multi-Mode Gated Timer Counter

This is a general-purpose counter/timer that runs in the system clock domain. It takes a slow source signal, a gate and an up/down line, and it drives one output pin and a count value that can be read back. Both the source and the gate pass through a two-flop synchronizer and an edge detector. The counter moves by one step for each active source edge that the detector sees. The gate does a different job in each of the four modes. In period measurement the gate edges bracket the counting window. In gated single-pulse mode the gate acts as a pause. In the two triggered modes the first gate edge starts the run and every later gate edge is ignored.

Software starts every run with a one-cycle start strobe. The strobe reloads the count from the initial value, drives the output to its inactive level and sends the state machine to the entry state of the selected mode. The source, the gate and the output each have a polarity control. The delay and width of a pulse are counted in active source edges, and a value of 0 is treated as 1.

States: IDLE (after reset), ARMED (waiting for an active gate edge), MEASURE (counting between gate edges), DELAY (the low phase before the pulse), WIDTH (the output is active) and DONE (finished, frozen). The transitions are:
- start to ARMED in period and triggered modes, and start to DELAY in gated mode.
- ARMED to MEASURE or DELAY on a gate edge.
- MEASURE to DONE on a gate edge.
- DELAY to WIDTH when the delay count is reached.
- WIDTH to DONE in the single-pulse modes, or WIDTH to DELAY in continuous mode, when the width count is reached.

Top module: `gated_counter_timer`

## Requirements
- R1: After reset `count_value` is 0 and the internal output level is low, so `timer_out` equals `out_pol`.
- R2: A high `sw_start` in one cycle loads `init_count` into `count_value` and drives the output to its inactive level at the next clock edge. This happens in any state.
- R3: When counting is enabled, each active source edge changes the count by +1 if `updown_in` is 1 and by -1 if it is 0. The count changes by at most one step per clock, and it never changes without an active source edge or a start. A source pin transition takes effect at the third rising clock edge after it.
- R4: Period mode (`mode_sel`=0) ignores source edges until the first active gate edge. It then counts until the second active gate edge. At that edge the output becomes active and the count freezes.
- R5: Gated single-pulse mode (`mode_sel`=1) starts counting right after the start. The output goes active on the delay-th enabled source edge and goes inactive on the width-th enabled edge after that. The run then ends.
- R6: In gated single-pulse mode, while the gate is inactive, the count and the pulse phase hold. Source edges in that time have no effect.
- R7: Triggered single-pulse mode (`mode_sel`=2) waits for an active gate edge and then produces one delay-then-width pulse. Gate edges after the first one are ignored until the next start. After the pulse the count stays frozen.
- R8: Triggered continuous mode (`mode_sel`=3) repeats the delay-then-width cycle for as long as source edges arrive after the first active gate edge.
- R9: A delay or width value of 0 acts as 1.
- R10: `src_pol`=1 makes the falling source edge active. `gate_pol`=1 inverts the gate level and makes its falling edge active. `out_pol`=1 inverts `timer_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 1 | Source clock pin, asynchronous |
| gate_in | input | 1 | Gate pin, asynchronous |
| updown_in | input | 1 | Direction: 1 counts up, 0 counts down |
| sw_start | input | 1 | Software start strobe, one cycle |
| mode_sel | input | 2 | 0 period, 1 gated pulse, 2 triggered pulse, 3 triggered continuous |
| src_pol | input | 1 | Source polarity: 1 means the falling edge is active |
| gate_pol | input | 1 | Gate polarity: 1 means low is active |
| out_pol | input | 1 | Output polarity: 1 inverts the output |
| init_count | input | CNT_W | Value loaded at start |
| delay_len | input | CNT_W | Delay or interval, in source edges |
| width_len | input | CNT_W | Pulse width, in source edges |
| timer_out | output | 1 | Counter output after polarity |
| count_value | output | CNT_W | Current count |

## Verification
The assertions check on every cycle that the count moves by at most one step and only after a detected source edge, that a start reloads the count and clears the output, and that nothing moves once the run is DONE. Only the bench scenarios can show the mode-specific behaviour: pulse placement for delay and width, that later gate edges are locked out, that the gate pauses the count, that period bracketing works, and that the polarity inversions apply. For these the bench compares against a behavioural model on every clock and also makes explicit value checks.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
    typedef enum logic [1:0] {
        MODE_PERIOD    = 2'd0,
        MODE_GATED     = 2'd1,
        MODE_TRIG_ONE  = 2'd2,
        MODE_TRIG_CONT = 2'd3
    } gtc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_MEASURE = 3'd2,
        ST_DELAY   = 3'd3,
        ST_WIDTH   = 3'd4,
        ST_DONE    = 3'd5
    } gtc_state_e;
endpackage

// File: rtl/gtc_edge_sync.sv
module gtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    output logic level,
    output logic edge_hit
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Edge direction is chosen from the raw history, so a polarity change alone never yields an edge.
    assign level    = sync_q[STAGES-1] ^ pol;
    assign edge_hit = pol ? (prev_q & ~sync_q[STAGES-1]) : (~prev_q & sync_q[STAGES-1]);
endmodule

// File: rtl/gtc_fsm.sv
module gtc_fsm
    import gtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate_lvl,
    input  logic             gate_edge,
    input  logic             count_up,
    input  logic             start,
    input  gtc_mode_e        mode,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] delay_val,
    input  logic [CNT_W-1:0] width_val,
    output logic             out_raw,
    output logic [CNT_W-1:0] count_q,
    output gtc_state_e       state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    gtc_state_e       nxt;
    gtc_state_e       entry_st;
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] delay_eff;
    logic [CNT_W-1:0] width_eff;
    logic             gate_ok;
    logic             step;
    logic             ph_inc;
    logic             ph_clr;
    logic             out_set;
    logic             out_clr;

    assign delay_eff = (delay_val == '0) ? ONE : delay_val;
    assign width_eff = (width_val == '0) ? ONE : width_val;
    assign gate_ok   = (mode == MODE_GATED) ? gate_lvl : 1'b1;
    assign entry_st  = (mode == MODE_GATED) ? ST_DELAY : ST_ARMED;

    always_comb begin
        nxt     = state;
        step    = 1'b0;
        ph_inc  = 1'b0;
        ph_clr  = 1'b0;
        out_set = 1'b0;
        out_clr = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ARMED: begin
                if (gate_edge) nxt = (mode == MODE_PERIOD) ? ST_MEASURE : ST_DELAY;
            end
            ST_MEASURE: begin
                step = tick;
                if (gate_edge) begin
                    nxt     = ST_DONE;
                    out_set = 1'b1;
                end
            end
            ST_DELAY: begin
                if (tick && gate_ok) begin
                    step = 1'b1;
                    if (phase_q == delay_eff - ONE) begin
                        nxt     = ST_WIDTH;
                        ph_clr  = 1'b1;
                        out_set = 1'b1;
                    end else begin
                        ph_inc = 1'b1;
                    end
                end
            end
            ST_WIDTH: begin
                if (tick && gate_ok) begin
                    step = 1'b1;
                    if (phase_q == width_eff - ONE) begin
                        nxt     = (mode == MODE_TRIG_CONT) ? ST_DELAY : ST_DONE;
                        ph_clr  = 1'b1;
                        out_clr = 1'b1;
                    end else begin
                        ph_inc = 1'b1;
                    end
                end
            end
            ST_DONE: ;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_IDLE;
        else if (start) state <= entry_st;
        else            state <= nxt;
    end

    // Outputs: count, phase, output level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            phase_q <= '0;
            out_raw <= 1'b0;
        end else if (start) begin
            count_q <= init_val;
            phase_q <= '0;
            out_raw <= 1'b0;
        end else begin
            if (step)        count_q <= count_up ? count_q + ONE : count_q - ONE;
            if (ph_clr)      phase_q <= '0;
            else if (ph_inc) phase_q <= phase_q + ONE;
            if (out_set)      out_raw <= 1'b1;
            else if (out_clr) out_raw <= 1'b0;
        end
    end
endmodule

// File: rtl/gated_counter_timer.sv
module gated_counter_timer
    import gtc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_in,
    input  logic             gate_in,
    input  logic             updown_in,
    input  logic             sw_start,
    input  logic [1:0]       mode_sel,
    input  logic             src_pol,
    input  logic             gate_pol,
    input  logic             out_pol,
    input  logic [CNT_W-1:0] init_count,
    input  logic [CNT_W-1:0] delay_len,
    input  logic [CNT_W-1:0] width_len,
    output logic             timer_out,
    output logic [CNT_W-1:0] count_value
);
    logic       src_lvl;
    logic       src_tick;
    logic       gate_lvl;
    logic       gate_edge;
    logic       out_raw;
    gtc_state_e fsm_state;

    gtc_edge_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .pin(src_in), .pol(src_pol),
        .level(src_lvl), .edge_hit(src_tick)
    );

    gtc_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .pin(gate_in), .pol(gate_pol),
        .level(gate_lvl), .edge_hit(gate_edge)
    );

    gtc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(src_tick), .gate_lvl(gate_lvl),
        .gate_edge(gate_edge), .count_up(updown_in), .start(sw_start),
        .mode(gtc_mode_e'(mode_sel)), .init_val(init_count),
        .delay_val(delay_len), .width_val(width_len),
        .out_raw(out_raw), .count_q(count_value), .state(fsm_state)
    );

    assign timer_out = out_raw ^ out_pol;

    logic unused_lvl;
    assign unused_lvl = src_lvl;
endmodule

// File: rtl/gtc_checker.sv
module gtc_checker
    import gtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_start,
    input logic             out_pol,
    input logic             timer_out,
    input logic [CNT_W-1:0] init_count,
    input logic [CNT_W-1:0] count_value,
    input logic             src_tick,
    input gtc_state_e       fsm_state
);
    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |=> (timer_out == out_pol));

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |=> (count_value == $past(init_count)));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_start |=> (count_value == $past(count_value)
                    || count_value == $past(count_value) + CNT_W'(1)
                    || count_value == $past(count_value) - CNT_W'(1)));

    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_start && !src_tick) |=> $stable(count_value));

    assert_done_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DONE && !sw_start) |=> ($stable(count_value) && fsm_state == ST_DONE));
endmodule

bind gated_counter_timer gtc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .out_pol(out_pol),
    .timer_out(timer_out), .init_count(init_count), .count_value(count_value),
    .src_tick(src_tick), .fsm_state(fsm_state)
);

// File: tb/gated_counter_timer_tb.sv
module gated_counter_timer_tb;
    localparam int W = 16;

    logic clk = 0, rst_n = 0;
    logic src_in = 0, gate_in = 0, updown_in = 1, sw_start = 0;
    logic [1:0] mode_sel = 0;
    logic src_pol = 0, gate_pol = 0, out_pol = 0;
    logic [W-1:0] init_count = 0, delay_len = 1, width_len = 1;
    logic timer_out;
    logic [W-1:0] count_value;

    int n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    gated_counter_timer #(.CNT_W(W)) u_dut (.*);

    // Behavioural reference: pins seen two clocks late, events applied on the third edge
    int s1, s2, sp, g1, g2, gp;
    int m_st, m_cnt, m_ph, m_out;
    int tk, ge, gl, d_e, w_e, en;

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = 0; s2 = 0; sp = 0; g1 = 0; g2 = 0; gp = 0;
            m_st = 0; m_cnt = 0; m_ph = 0; m_out = 0;
        end else begin
            tk = src_pol ? (sp == 1 && s2 == 0) : (sp == 0 && s2 == 1);
            ge = gate_pol ? (gp == 1 && g2 == 0) : (gp == 0 && g2 == 1);
            gl = g2 ^ gate_pol;
            d_e = (delay_len == 0) ? 1 : int'(delay_len);
            w_e = (width_len == 0) ? 1 : int'(width_len);
            en = (mode_sel == 1) ? gl : 1;
            if (sw_start) begin
                m_cnt = int'(init_count); m_ph = 0; m_out = 0;
                m_st = (mode_sel == 1) ? 3 : 1;
            end else begin
                case (m_st)
                    1: if (ge) m_st = (mode_sel == 0) ? 2 : 3;
                    2: begin
                        if (tk) m_cnt = m_cnt + (updown_in ? 1 : -1);
                        if (ge) begin m_st = 5; m_out = 1; end
                    end
                    3, 4: if (tk && en) begin
                        m_cnt = m_cnt + (updown_in ? 1 : -1);
                        m_ph = m_ph + 1;
                        if (m_st == 3 && m_ph == d_e) begin
                            m_st = 4; m_ph = 0; m_out = 1;
                        end else if (m_st == 4 && m_ph == w_e) begin
                            m_ph = 0; m_out = 0;
                            m_st = (mode_sel == 3) ? 3 : 5;
                        end
                    end
                    default: ;
                endcase
                m_cnt = m_cnt & 32'hFFFF;
            end
            sp = s2; s2 = s1; s1 = src_in;
            gp = g2; g2 = g1; g1 = gate_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (timer_out !== 1'(m_out ^ out_pol) || count_value !== W'(m_cnt)) begin
                n_fail++;
                $display("FAIL %s model: out=%0b cnt=%0d expected out=%0b cnt=%0d",
                         cur_req, timer_out, count_value, m_out ^ out_pol, m_cnt);
            end
        end
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask

    task automatic expect_vals(string req, logic eo, int ec);
        n_checks++;
        if (timer_out !== eo || count_value !== W'(ec)) begin
            n_fail++;
            $display("FAIL %s: out=%0b cnt=%0d expected out=%0b cnt=%0d",
                     req, timer_out, count_value, eo, ec);
        end
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            src_in = ~src_in; cyc(3); src_in = ~src_in; cyc(3);
        end
        cyc(2);
    endtask

    task automatic set_gate(logic v); gate_in = v; cyc(5); endtask

    task automatic start(); sw_start = 1; cyc(1); sw_start = 0; cyc(1); endtask

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        expect_vals("R1", 1'b0, 0);

        // Period mode, counting up
        cur_req = "R4"; mode_sel = 0; init_count = 5; updown_in = 1;
        start();
        expect_vals("R2", 1'b0, 5);
        pulses(3);
        expect_vals("R4", 1'b0, 5);          // ignored before first gate edge
        set_gate(1); pulses(4);
        expect_vals("R3", 1'b0, 9);
        set_gate(0); set_gate(1);
        expect_vals("R4", 1'b1, 9);
        pulses(2);
        expect_vals("R4", 1'b1, 9);

        // Period mode, counting down
        cur_req = "R3"; set_gate(0); init_count = 10; updown_in = 0;
        start(); set_gate(1); pulses(3); set_gate(0); set_gate(1);
        expect_vals("R3", 1'b1, 7);

        // Gated single pulse, delay 2 width 4, with pause
        cur_req = "R5"; mode_sel = 1; init_count = 0; updown_in = 1;
        delay_len = 2; width_len = 4;
        start(); pulses(1);
        expect_vals("R5", 1'b0, 1);
        pulses(1);
        expect_vals("R5", 1'b1, 2);
        pulses(3);
        expect_vals("R5", 1'b1, 5);
        cur_req = "R6"; set_gate(0); pulses(3);
        expect_vals("R6", 1'b1, 5);
        set_gate(1); pulses(1);
        expect_vals("R5", 1'b0, 6);
        pulses(1);
        expect_vals("R5", 1'b0, 6);

        // Triggered single pulse, later gate edges locked out
        cur_req = "R7"; set_gate(0); mode_sel = 2; init_count = 100;
        start(); pulses(2);
        expect_vals("R7", 1'b0, 100);
        set_gate(1); pulses(2);
        expect_vals("R7", 1'b1, 102);
        set_gate(0); set_gate(1); pulses(4);
        expect_vals("R7", 1'b0, 106);
        set_gate(0); set_gate(1); pulses(3);
        expect_vals("R7", 1'b0, 106);
        start();
        expect_vals("R2", 1'b0, 100);

        // Triggered continuous, delay 1 width 2
        cur_req = "R8"; set_gate(0); mode_sel = 3; init_count = 0;
        delay_len = 1; width_len = 2;
        start(); set_gate(1); pulses(4);
        expect_vals("R8", 1'b1, 4);
        pulses(2);
        expect_vals("R8", 1'b0, 6);
        pulses(1);
        expect_vals("R8", 1'b1, 7);

        // Zero delay and width act as one
        cur_req = "R9"; mode_sel = 1; delay_len = 0; width_len = 0;
        start(); pulses(1);
        expect_vals("R9", 1'b1, 1);
        pulses(1);
        expect_vals("R9", 1'b0, 2);

        // Polarity controls, period mode
        cur_req = "R10"; set_gate(0); mode_sel = 0;
        src_pol = 1; gate_pol = 1; out_pol = 1; cyc(2);
        start();
        expect_vals("R10", 1'b1, 0);
        set_gate(1); pulses(2);
        expect_vals("R10", 1'b1, 0);         // before active (falling) gate edge
        set_gate(0); pulses(3);
        set_gate(1); set_gate(0);
        expect_vals("R10", 1'b0, 3);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule